// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block sits between a flash cycle requester and the flash cycle engine. It decides, in the same clock as the request, whether a cycle may start. Five range registers each hold a lower and an upper page limit at 4 KB granularity. Each register also has its own enable for guarding write/erase cycles and its own enable for guarding read cycles. A cycle whose address falls inside a guarded range is refused, and the refusal is reported as a cycle error.

The ranges are programmed through a simple register write port and can be read back. They have no effect until a sticky lockdown is set. From the moment of lockdown the ranges are enforced, and every register write is dropped until the next reset. This lets boot code arrange the protected areas and then freeze them for the rest of the session.

Register layout (32 bits, fixed because software encodes it):
- bit 31: write/erase guard enable.
- bits 28:16: upper page, which is address bits 24:12. The low 12 address bits are taken as 0xFFF.
- bit 15: read guard enable.
- bits 12:0: lower page, which is address bits 24:12. The low 12 address bits are taken as 0x000.
- bits 30:29 and 14:13: reserved.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, `locked` is 0, every range register reads back as 0, and every requested cycle is granted.
- R2: A write to register index 0..4 while unlocked stores bit 31, bits 28:16, bit 15 and bits 12:0. Bits 30:29 and 14:13 always read back as 0, whatever was written to them.
- R3: While `locked` is 0, no cycle is denied, whatever the range settings are.
- R4: A pulse on `lock_set` makes `locked` 1 from the next clock until reset. While locked, register writes are ignored and read-back data does not change.
- R5: When locked, a write/erase cycle (`req_write`=1) is denied if address bits 24:12 lie in [lower, upper] of any range with bit 31 set. Bit 15 of a range has no effect on write/erase cycles.
- R6: When locked, a read cycle (`req_write`=0) is denied if address bits 24:12 lie in [lower, upper] of any range with bit 15 set. Bit 31 of a range has no effect on read cycles.
- R7: Both limits are inclusive at page granularity. Address upper*4096+0xFFF and address lower*4096 fall inside the range. Address (upper+1)*4096 and address lower*4096-1 fall outside it.
- R8: A range whose lower page is greater than its upper page matches no address.
- R9: A denied request drives `cycle_err`=1 and `grant`=0 combinationally in the request's own clock. An allowed request drives `grant`=1 and `cycle_err`=0. With `req_valid`=0, both outputs are 0.
- R10: Writes to indices 5..7 change no register, and reads of indices 5..7 return 0.
- R11: Each of the five ranges can cause a denial on its own; the outcome is the OR over all ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_widx | input | 3 | Register index for write |
| cfg_wdata | input | 32 | Register write data |
| cfg_ridx | input | 3 | Register index for read-back |
| cfg_rdata | output | 32 | Read-back data, reserved bits zero |
| lock_set | input | 1 | Pulse to set the sticky lockdown |
| locked | output | 1 | Lockdown state |
| req_valid | input | 1 | Flash cycle request |
| req_addr | input | 25 | Flash cycle byte address |
| req_write | input | 1 | 1 = write/erase, 0 = read |
| grant | output | 1 | Cycle may start |
| cycle_err | output | 1 | Cycle refused, reported as a cycle error |

## Verification
The assertions assume three things about the inputs:
- The inputs are stable around the rising edge.
- `cfg_ridx` is held steady whenever the checks compare read-back across cycles.
- `lock_set` is a level sampled only at the edge.

The stimulus changes every input on the falling edge and samples outputs shortly after it. During lockdown, read-back is probed with a held index while writes are attempted, so any change seen in the read-back data comes from a register and not from the multiplexer.

// File: rtl/prot_range_pkg.sv
package prot_range_pkg;
  localparam int PAGE_W     = 13;
  localparam int PAGE_SHIFT = 12;
  localparam int ADDR_W     = PAGE_W + PAGE_SHIFT;
  localparam int REG_W      = 32;
  // field positions decoded by software
  localparam int WP_BIT     = 31;
  localparam int RP_BIT     = 15;
  localparam int HI_LSB     = 16;
  localparam int LO_LSB     = 0;

  typedef struct packed {
    logic              wp;
    logic              rp;
    logic [PAGE_W-1:0] hi;
    logic [PAGE_W-1:0] lo;
  } range_cfg_t;

  function automatic range_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
    range_cfg_t c;
    c.wp = w[WP_BIT];
    c.rp = w[RP_BIT];
    c.hi = w[HI_LSB +: PAGE_W];
    c.lo = w[LO_LSB +: PAGE_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input range_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[WP_BIT] = c.wp;
    w[RP_BIT] = c.rp;
    w[HI_LSB +: PAGE_W] = c.hi;
    w[LO_LSB +: PAGE_W] = c.lo;
    return w;
  endfunction
endpackage

// File: rtl/prot_range_lock.sv
module prot_range_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_set,
  output logic locked
);
  logic lock_d;

  always_comb begin
    lock_d = locked | lock_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= lock_d;
  end
endmodule

// File: rtl/prot_range_reg.sv
module prot_range_reg
  import prot_range_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  range_cfg_t wr_cfg,
  output range_cfg_t cfg_q
);
  range_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/prot_range_match.sv
module prot_range_match
  import prot_range_pkg::*;
(
  input  range_cfg_t        cfg,
  input  logic [PAGE_W-1:0] page,
  input  logic              is_write,
  output logic              hit
);
  logic in_span;
  logic guard_on;

  always_comb begin
    // an inverted range (lo > hi) can never satisfy both compares
    in_span  = (page >= cfg.lo) && (page <= cfg.hi);
    guard_on = is_write ? cfg.wp : cfg.rp;
    hit      = in_span && guard_on;
  end
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import prot_range_pkg::*;
#(
  parameter int N_RANGES = 5,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_widx,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [IDX_W-1:0]  cfg_ridx,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lock_set,
  output logic              locked,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              grant,
  output logic              cycle_err
);
  range_cfg_t        cfg_q [N_RANGES];
  logic [N_RANGES-1:0] wr_sel;
  logic [N_RANGES-1:0] hit;
  logic [PAGE_W-1:0] req_page;
  range_cfg_t        wr_cfg;
  logic              deny;

  assign req_page = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign wr_cfg   = unpack_cfg(cfg_wdata);

  prot_range_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_set (lock_set),
    .locked   (locked)
  );

  for (genvar g = 0; g < N_RANGES; g++) begin : g_range
    assign wr_sel[g] = cfg_we && !locked && (cfg_widx == IDX_W'(g));

    prot_range_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_sel[g]),
      .wr_cfg (wr_cfg),
      .cfg_q  (cfg_q[g])
    );

    prot_range_match u_match (
      .cfg      (cfg_q[g]),
      .page     (req_page),
      .is_write (req_write),
      .hit      (hit[g])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < N_RANGES; i++) begin
      if (cfg_ridx == IDX_W'(i)) cfg_rdata = pack_cfg(cfg_q[i]);
    end
  end

  always_comb begin
    deny      = req_valid && locked && (|hit);
    cycle_err = deny;
    grant     = req_valid && !deny;
  end
endmodule

// File: rtl/flash_range_guard_chk.sv
module flash_range_guard_chk
  import prot_range_pkg::*;
#(
  parameter int N_RANGES = 5,
  parameter int IDX_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_widx,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [IDX_W-1:0]  cfg_ridx,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              lock_set,
  input logic              locked,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              grant,
  input logic              cycle_err
);
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_lock_follows_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked);

  p_frozen_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locked) && $stable(cfg_ridx)) |-> $stable(cfg_rdata));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[30:29] == 2'b00) && (cfg_rdata[14:13] == 2'b00));

  p_open_before_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && req_valid) |-> (grant && !cycle_err));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({grant, cycle_err}));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !cycle_err));
endmodule

bind flash_range_guard flash_range_guard_chk #(
  .N_RANGES (N_RANGES),
  .IDX_W    (IDX_W)
) chk_i (.*);

// File: tb/flash_range_guard_tb_top.sv
module flash_range_guard_tb_top;
  import prot_range_pkg::*;

  localparam int N = 5;
  localparam int IW = 3;

  logic clk, rst_n;
  logic cfg_we;
  logic [IW-1:0] cfg_widx, cfg_ridx;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic lock_set, locked;
  logic req_valid, req_write, grant, cycle_err;
  logic [24:0] req_addr;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mdl_reg [N];
  logic        mdl_lock;

  flash_range_guard #(.N_RANGES(N), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
    .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
    .lock_set(lock_set), .locked(locked), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .grant(grant),
    .cycle_err(cycle_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic mdl_deny(input logic [24:0] a, input logic w);
    logic d;
    logic [12:0] pg;
    d  = 1'b0;
    pg = a[24:12];
    for (int i = 0; i < N; i++) begin
      if (pg >= mdl_reg[i][12:0] && pg <= mdl_reg[i][28:16] &&
          (w ? mdl_reg[i][31] : mdl_reg[i][15]))
        d = 1'b1;
    end
    return mdl_lock && d;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 0; cfg_widx = 0; cfg_wdata = 0; cfg_ridx = 0;
    lock_set = 0; req_valid = 0; req_addr = 0; req_write = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) mdl_reg[i] = '0;
    mdl_lock = 1'b0;
  endtask

  task automatic reg_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_widx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (idx < N && !mdl_lock) mdl_reg[idx] = d & 32'h9FFF_9FFF;
  endtask

  task automatic reg_read(input string tag, input int idx, input logic [31:0] exp);
    cfg_ridx = IW'(idx);
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic cyc(input string tag, input logic [24:0] a, input logic w);
    logic d;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    #1;
    d = mdl_deny(a, w);
    check({tag, " grant"}, {31'b0, grant}, {31'b0, ~d});
    check({tag, " err"}, {31'b0, cycle_err}, {31'b0, d});
    req_valid = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R1 locked", {31'b0, locked}, 32'd0);
    for (int i = 0; i < N; i++) reg_read("R1 reg zero", i, 32'd0);
    cyc("R1 read open", 25'h000000, 1'b0);
    cyc("R1 write open", 25'h1FFFFFF, 1'b1);
  endtask

  task automatic t_program();
    reg_write(0, 32'hE01F_6010);  // wp, hi 0x1F, lo 0x10, reserved bits set
    reg_read("R2 reserved masked", 0, 32'h801F_0010);
    reg_write(1, 32'h0100_8100);  // rp only, single page 0x100
    reg_write(2, 32'h8040_8050);  // both, inverted lo 0x50 > hi 0x40
    reg_write(3, 32'h9FFF_1FFF);  // wp, top page
    reg_write(4, 32'h0000_8000);  // rp, page 0
    reg_read("R2 reg1", 1, 32'h0100_8100);
    reg_read("R2 reg3", 3, 32'h1FFF_1FFF | 32'h8000_0000);
    reg_write(5, 32'hFFFF_FFFF);
    reg_write(7, 32'hFFFF_FFFF);
    reg_read("R10 idx5 zero", 5, 32'd0);
    reg_read("R10 idx7 zero", 7, 32'd0);
    reg_read("R10 reg0 kept", 0, 32'h801F_0010);
    reg_read("R10 reg4 kept", 4, 32'h0000_8000);
  endtask

  task automatic t_unlocked_open();
    cyc("R3 write in r0", 25'h0010000, 1'b1);
    cyc("R3 read in r1", 25'h0100000, 1'b0);
  endtask

  task automatic t_lock();
    @(negedge clk);
    lock_set = 1;
    @(negedge clk);
    lock_set = 0;
    mdl_lock = 1;
    check("R4 locked", {31'b0, locked}, 32'd1);
    cfg_ridx = 0;
    reg_write(0, 32'h0000_0000);
    reg_write(3, 32'h0000_0000);
    reg_read("R4 reg0 frozen", 0, 32'h801F_0010);
    reg_read("R4 reg3 frozen", 3, 32'h9FFF_1FFF);
    @(negedge clk);
    check("R4 still locked", {31'b0, locked}, 32'd1);
  endtask

  task automatic t_enforce();
    cyc("R5 write in r0", 25'h0010000, 1'b1);
    cyc("R5 read in r0 wp-only", 25'h0010000, 1'b0);
    cyc("R7 upper edge in", 25'h001FFFF, 1'b1);
    cyc("R7 upper edge out", 25'h0020000, 1'b1);
    cyc("R7 lower edge out", 25'h000FFFF, 1'b1);
    cyc("R6 read in r1", 25'h0100000, 1'b0);
    cyc("R6 read end r1", 25'h0100FFF, 1'b0);
    cyc("R6 write in r1 rp-only", 25'h0100000, 1'b1);
    cyc("R8 inverted read", 25'h0045000, 1'b0);
    cyc("R8 inverted write", 25'h0045000, 1'b1);
    cyc("R11 r3 top write", 25'h1FFFFFF, 1'b1);
    cyc("R11 r4 page0 read", 25'h0000ABC, 1'b0);
    cyc("R11 r4 page0 write", 25'h0000ABC, 1'b1);
    @(negedge clk);
    req_valid = 0; req_addr = 25'h0010000; req_write = 1;
    #1;
    check("R9 idle grant", {31'b0, grant}, 32'd0);
    check("R9 idle err", {31'b0, cycle_err}, 32'd0);
  endtask

  task automatic t_reset_clears();
    do_reset();
    @(negedge clk);
    check("R1 unlock after reset", {31'b0, locked}, 32'd0);
    reg_read("R1 reg0 cleared", 0, 32'd0);
    cyc("R1 open after reset", 25'h0010000, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_program();
    t_unlocked_open();
    t_lock();
    t_enforce();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule